// File: doc/BRIEF.md
# Banked GPIO Register Block

A memory-mapped general-purpose I/O block. It groups its pins into banks of eight. Each bank exposes two 32-bit registers on a simple synchronous bus: a data register and a direction register. Software uses the direction register to make each pin an input or an output. It writes the data register to set output levels. It reads the data register to see output levels and the live, synchronised level of input pins.

Pin p belongs to bank p/8 at bit p%8. Bank register addresses follow a fixed offset formula. One reserved address window sits inside the register space and holds no registers, so banks that would land in it are moved past it. Writes take effect at the next clock edge. Reads return data combinationally from the presented address.

Top module: `bank_gpio`

## Requirements
- R1: After reset every direction bit is 1, every output latch bit is 0 and `pad_oe` is all zero.
- R2: Bank b has its register base at (b+1)*8. If that base is 0x90 or more, 0x10 is added to it. The data register sits at the base and the direction register at base+4.
- R3: Reads return zero, and writes change nothing, for addresses 0x90 to 0x9F, for addresses not 32-bit aligned, and for addresses that belong to no bank.
- R4: A direction bit of 1 makes its pin an input with `pad_oe` low. A direction bit of 0 makes it an output with `pad_oe` high.
- R5: For input pins, a data register read returns the pad level sampled through a two-flop synchroniser. A pad change made before a clock edge is visible after the second rising edge.
- R6: For output pins, a data register read returns the output latch.
- R7: A write to a data register always loads all eight latch bits, including bits of input pins, whatever was read before. `pad_out` shows the latch from the next edge on.
- R8: Only bits 7:0 of a bank register are stored. Read bits 31:8 are always zero.
- R9: If the data latch is loaded while a pin is an input, clearing its direction bit later drives the new value from the first cycle `pad_oe` is high.
- R10: Register writes take effect at the rising edge where `bus_wen` is high. The direction register reads back as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wen | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | NUM_BANKS*8 (160) | Pad input levels |
| pad_out | output | NUM_BANKS*8 (160) | Output latch toward the pads |
| pad_oe | output | NUM_BANKS*8 (160) | Per-pin output enable |

## Verification
The assertions assume a bus write lasts exactly the cycle in which `bus_wen` is high. They also assume the pads only move output state through bus writes. The stimulus drives every bus input at the falling edge, so nothing changes near the sampling edge. The bench holds `pad_in` steady for three cycles after each change before it reads data registers, which keeps the synchroniser latency out of the expected values. Random addresses cover the whole 8-bit space, misaligned ones included, so the hole and unmapped regions are hit as well as real banks.

// File: rtl/gpio_pkg.sv
// Shared constants and the bank address formula for the banked GPIO block.
// Assumes byte addressing and 32-bit registers.
package gpio_pkg;
    localparam int PINS_PER_BANK = 8;
    localparam int DIR_OFFSET    = 4;
    localparam int HOLE_LO       = 'h90;
    localparam int HOLE_SIZE     = 'h10;

    // Register base of bank b, skipping the reserved window.
    function automatic int bank_base(input int b);
        int a;
        a = (b + 1) * 8;
        if (a >= HOLE_LO) a = a + HOLE_SIZE;
        return a;
    endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
// Address decoder: finds which bank register, if any, an address selects.
// Assumes ADDR_W is wide enough to hold the highest bank address.
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 20,
    parameter int ADDR_W    = 8,
    parameter int IDX_W     = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              sel_dir,
    output logic [IDX_W-1:0]  bank_idx
);
    // Compare the address against every bank's data and direction slot.
    always_comb begin
        hit      = 1'b0;
        sel_dir  = 1'b0;
        bank_idx = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(bank_base(b))) begin
                hit      = 1'b1;
                sel_dir  = 1'b0;
                bank_idx = IDX_W'(b);
            end else if (addr == ADDR_W'(bank_base(b) + DIR_OFFSET)) begin
                hit      = 1'b1;
                sel_dir  = 1'b1;
                bank_idx = IDX_W'(b);
            end
        end
    end
endmodule

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for asynchronous pad inputs.
// Assumes each bit is independent; there is no bus coherency across bits.
module gpio_sync #(
    parameter int WIDTH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// One bank of eight pins: output latch, direction latch and data readback.
// Assumes at most one of the two write enables is high in a cycle.
module gpio_bank
    import gpio_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_data,
    input  logic                     wr_dir,
    input  logic [PINS_PER_BANK-1:0] wdata,
    input  logic [PINS_PER_BANK-1:0] pin_sync,
    output logic [PINS_PER_BANK-1:0] out_q,
    output logic [PINS_PER_BANK-1:0] dir_q,
    output logic [PINS_PER_BANK-1:0] data_rd
);
    // Output latch: loaded on every data write, whatever the direction.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (wr_data) out_q <= wdata;
    end

    // Direction latch: 1 means input, reset to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (wr_dir) dir_q <= wdata;
    end

    // Readback: live pin for inputs, latch for outputs.
    always_comb data_rd = (dir_q & pin_sync) | (~dir_q & out_q);
endmodule

// File: rtl/bank_gpio.sv
// Banked GPIO top: decodes the bus, holds the per-bank latches, drives the pads.
// Assumes single-cycle writes and a combinational read of the addressed register.
module bank_gpio
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 20,
    parameter int ADDR_W    = 8,
    localparam int NPINS    = NUM_BANKS * PINS_PER_BANK,
    localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    logic             hit;
    logic             sel_dir;
    logic [IDX_W-1:0] bank_idx;
    logic [NPINS-1:0] pin_sync;
    logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0] out_v, dir_v, rd_v;

    gpio_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr(bus_addr), .hit(hit), .sel_dir(sel_dir), .bank_idx(bank_idx)
    );

    gpio_sync #(.WIDTH(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        // Per-bank select from the decoder.
        always_comb sel = bus_wen && hit && (bank_idx == IDX_W'(b));

        gpio_bank u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_data(sel && !sel_dir),
            .wr_dir(sel && sel_dir),
            .wdata(bus_wdata[PINS_PER_BANK-1:0]),
            .pin_sync(pin_sync[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .out_q(out_v[b]), .dir_q(dir_v[b]), .data_rd(rd_v[b])
        );

        assign pad_out[b*PINS_PER_BANK +: PINS_PER_BANK] = out_v[b];
        assign pad_oe[b*PINS_PER_BANK +: PINS_PER_BANK]  = ~dir_v[b];
    end

    // Read mux: selected register in the low byte, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (hit)
            bus_rdata[PINS_PER_BANK-1:0] = sel_dir ? dir_v[bank_idx] : rd_v[bank_idx];
    end
endmodule

// File: rtl/bank_gpio_checker.sv
// Property checker for bank_gpio, attached by bind.
module bank_gpio_checker #(
    parameter int ADDR_W = 8,
    parameter int NPINS  = 160
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wen,
    input logic [31:0]       bus_rdata,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe
);
    logic in_hole;
    // Flags addresses inside the reserved window.
    always_comb in_hole = (int'(bus_addr) >= 'h90) && (int'(bus_addr) <= 'h9F);

    // R1: the edge after a reset cycle leaves the pads undriven.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0));

    // R10: without a write the pad state holds.
    a_r10_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wen |=> ($stable(pad_out) && $stable(pad_oe)));

    // R3: writes into the hole change nothing.
    a_r3_hole_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && in_hole) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R3: reads in the hole return zero.
    a_r3_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_hole |-> bus_rdata == '0);

    // R8: the upper read bits are always zero.
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:8] == '0);
endmodule

bind bank_gpio bank_gpio_checker #(.ADDR_W(ADDR_W), .NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/bank_gpio_test.sv
module bank_gpio_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 20;
    localparam int NP = NB * 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wen = 0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;

    logic [NP-1:0] m_out, m_dir;
    int checks = 0, errors = 0;

    bank_gpio #(.NUM_BANKS(NB), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench view of the address map (R2, R3).
    function automatic bit lookup(input int a, output int bank, output bit isdir);
        bank = 0; isdir = 0;
        for (int b = 0; b < NB; b++) begin
            int base = (b + 1) * 8;
            if (base >= 'h90) base += 'h10;
            if (a == base)     begin bank = b; isdir = 0; return 1; end
            if (a == base + 4) begin bank = b; isdir = 1; return 1; end
        end
        return 0;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        int b; bit d;
        logic [NP-1:0] mix;
        if (!lookup(a, b, d)) return 32'h0;
        mix = (m_dir & pad_in) | (~m_dir & m_out);
        return d ? {24'h0, m_dir[b*8 +: 8]} : {24'h0, mix[b*8 +: 8]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pads(input string tag);
        check(pad_out == m_out, {tag, " pad_out"}, pad_out, m_out);
        check(pad_oe == ~m_dir, {tag, " pad_oe"}, pad_oe, ~m_dir);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        int b; bit isd;
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = d; bus_wen = 1;
        @(negedge clk);
        bus_wen = 0;
        if (lookup(a, b, isd)) begin
            if (isd) m_dir[b*8 +: 8] = d[7:0];
            else     m_out[b*8 +: 8] = d[7:0];
        end
    endtask

    task automatic rd_check(input int a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = 8'(a);
        #1;
        e = exp_read(a);
        check(bus_rdata == e, tag, NP'(bus_rdata), NP'(e));
    endtask

    task automatic set_pads(input logic [NP-1:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20150701));
        m_out = '0; m_dir = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_pads("R1 reset");
        rd_check('h0C, "R1 dir reset read");

        // R5: inputs read the synchronised pads.
        set_pads({5{32'hA5C3_0F96}});
        rd_check('h08, "R5 bank0 input");
        rd_check('hA0, "R5 bank17 input");
        // R5 latency: not visible after one edge, visible after two.
        @(negedge clk); pad_in[7:0] = 8'h3C; bus_addr = 8'h08;
        @(negedge clk); #1;
        check(bus_rdata[7:0] == 8'h96, "R5 one edge old", NP'(bus_rdata), NP'(8'h96));
        @(negedge clk); #1;
        check(bus_rdata[7:0] == 8'h3C, "R5 two edges new", NP'(bus_rdata), NP'(8'h3C));

        // R9: load latch while input, then switch to output.
        wr('h10, 32'h0000_00A5);
        check_pads("R7 latch loads on input pin");
        wr('h14, 32'h0);
        check_pads("R9 new value on first output cycle");
        rd_check('h10, "R6 output readback");
        // R7: rewrite same value, then a change.
        wr('h10, 32'h0000_00A5);
        wr('h10, 32'h0000_005A);
        check_pads("R7 rewrite");
        // R8: upper bits dropped.
        wr('h88, 32'hFFFF_FF3C);
        wr('h8C, 32'hFFFF_FF0F);
        rd_check('h88, "R8 upper bits zero");
        rd_check('h8C, "R10 dir readback");
        check_pads("R4 mixed directions");
        // R2: hole-shifted banks.
        wr('hA4, 32'h00);
        wr('hA0, 32'h77);
        wr('hB4, 32'hF0);
        wr('hB0, 32'h1E);
        check_pads("R2 shifted banks");
        rd_check('hB0, "R2 bank19 data");
        // R3: hole, misaligned, beyond.
        wr('h90, 32'hFF); wr('h94, 32'h00); wr('h9C, 32'h00);
        wr('h11, 32'h00); wr('h16, 32'hFF); wr('hC0, 32'h00); wr('h00, 32'h00);
        check_pads("R3 ignored writes");
        rd_check('h90, "R3 hole read");
        rd_check('h12, "R3 misaligned read");
        rd_check('hF8, "R3 beyond read");

        // Random phase.
        for (int i = 0; i < 400; i++) begin
            int a = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : ($urandom_range(0, 63) * 4);
            case ($urandom_range(0, 4))
                0: set_pads({$urandom, $urandom, $urandom, $urandom, $urandom});
                1, 2: begin wr(a, $urandom); check_pads("R7 random write"); end
                default: rd_check(a, "R6 random read");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule